// File: doc/BRIEF.md
# Gated Multi-Rate Clock Distributor

This block turns one master clock (nominally 200 MHz) into a family of related clocks. One main output runs at the master rate or at half of it. A pair of half-rate outputs runs at a quarter of the master rate. A set of eighth-rate outputs completes the family: one lead output and three lag outputs. All slow outputs come from registers driven by a shared phase counter, so their edge positions relative to one another are fixed. The lag outputs are re-registered on the falling master edge, which places them half a master period behind the lead output.

Four control inputs shape the output set. Each is passed through a two-flop synchronizer first. A rate select picks the speed of the main output. A mid-stop holds both quarter-rate outputs low. A two-bit stop code picks one lag output to hold low. A power-down drives every output low. A stop or power-down lets the affected output make a counted number of further transitions and always leaves it low. When the request is released, the output restarts at a point where its waveform is low, so the phase relationships are preserved. After power-down is released, the phase counter restarts from a common point, and all running outputs then rise together.

Top module: `clkdist_gated`

## Requirements
- R1: While reset is asserted, every output is low.
- R2: With rate select low, the main output makes one rise every 2 master cycles; with rate select high, one rise every master cycle. Each quarter-rate output rises once every 4 master cycles. The lead output and each running lag output rise once every 8 master cycles.
- R3: While no power-down is in progress, every rise of a quarter-rate output coincides with a rise of the main output. Every rise of the lead output also coincides with a rise of the main output.
- R4: Every rise of a lag output comes exactly half a master period after a rise of the lead output.
- R5: Mid-stop high, applied between master edges: each quarter-rate output makes 2 or 3 more transitions (synchronizer latency, one counted transition, completion of a high phase), then stays low. The main and lead outputs keep running. When mid-stop is released, the quarter-rate outputs return to full rate.
- R6: Stop code selects the lag output to hold low: 00 selects lag output 0, 01 selects lag output 1, 10 selects lag output 2, and 11 selects none. Outputs that are not selected keep running at full rate.
- R7: The selected lag output makes 2 to 4 further transitions after the code is applied (two counted transitions, plus latency and rounding to low), then stays low. Deselecting it restores full rate.
- R8: Power-down high: every output makes between 3 and 10 further transitions (at least three counted transitions of its own), then all outputs stay low while power-down is held.
- R9: Power-down low, applied between master edges: all outputs stay low through the first five master rising edges. On the sixth edge the main output, both quarter-rate outputs and the lead output rise together. The lag outputs rise half a master period later. The six edges are made up of two for synchronizing, a two-cycle resume delay, one enable cycle and one alignment cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_sel | input | 1 | 1: main output at master rate; 0: half rate |
| stop_mid | input | 1 | Holds the quarter-rate outputs low |
| stop_code | input | 2 | Selects the lag output to hold low (11 = none) |
| pwr_down | input | 1 | Drives all outputs low after counted transitions |
| clk_main | output | 1 | Main output, master or half rate |
| clk_half | output | 2 | Quarter-rate outputs, in phase with the main output |
| clk_lead | output | 1 | Eighth-rate lead output |
| clk_lag | output | N_SKEW | Eighth-rate outputs, half a master period after the lead output |

## Verification
A corrupted phase counter shows up at the ports within one eighth-rate period: a quarter-rate or lead rise no longer lands on a main-output rise, or rise counts over a 64-cycle window move away from 32, 16 and 8. A transition counter that saturates at the wrong value or never clears changes how many edges an output makes after a stop. It can also leave the output stuck high, or leave it dead after release; the stop-window transition bounds catch this within a few tens of cycles. A broken resume sequencer moves the common restart edge away from the sixth master edge after release, and the edge-by-edge resume check reports it at once.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;
  localparam int PH_W   = 3;
  localparam int CNT_W  = 3;
  localparam int CODE_W = 2;

  typedef logic [CNT_W-1:0] tcnt_t;

  typedef struct packed {
    logic              fast;
    logic              stop_mid;
    logic [CODE_W-1:0] code;
    logic              pd;
  } ctl_t;
endpackage

// File: rtl/clkdist_sync.sv
module clkdist_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= rst_val;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/clkdist_phase.sv
module clkdist_phase
  import clkdist_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  output logic [PH_W-1:0] ph_q,
  output logic [PH_W-1:0] ph_d
);
  // All-ones is the rest phase: every derived waveform is low there,
  // and the step to zero makes every waveform rise on one edge.
  always_comb begin
    if (hold) ph_d = '1;
    else      ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '1;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/clkdist_gate.sv
module clkdist_gate
  import clkdist_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  tcnt_t      lim,
  input  logic [1:0] step,
  input  logic       wave_q,
  input  logic       wave_d,
  output logic       en_q,
  output logic       en_d
);
  tcnt_t            cnt_q, cnt_d, csat;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum  = {1'b0, cnt_q} + (CNT_W+1)'(step);
    csat = (sum > {1'b0, lim}) ? lim : sum[CNT_W-1:0];
    if (!req) begin
      cnt_d = '0;
      // restart only where the waveform is low, so no short pulse
      en_d  = en_q | ~wave_q;
    end else begin
      cnt_d = csat;
      // stop only at a point where the waveform is going or staying low
      en_d  = en_q & ~((csat >= lim) & ~wave_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  // R5, R7, R8: an output is only shut off while a request is pending
  p_en_drop_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(req));

  // R9: an output is only re-enabled while its waveform is low
  p_en_rise_at_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(!wave_q));
endmodule

// File: rtl/clkdist_gated.sv
module clkdist_gated
  import clkdist_pkg::*;
#(
  parameter int N_SKEW     = 3,
  parameter int SYNC_STG   = 2,
  parameter int RESUME_CYC = 2,
  parameter int STOP_MID_N = 1,
  parameter int STOP_LAG_N = 2,
  parameter int PD_N       = 3
) (
  input  logic              clk_mst,
  input  logic              rst_n,
  input  logic              fast_sel,
  input  logic              stop_mid,
  input  logic [1:0]        stop_code,
  input  logic              pwr_down,
  output logic              clk_main,
  output logic [1:0]        clk_half,
  output logic              clk_lead,
  output logic [N_SKEW-1:0] clk_lag
);
  localparam int CTL_W = $bits(ctl_t);
  localparam int RC_W  = $clog2(RESUME_CYC + 1);

  // ---------------- control synchronizer ----------------
  logic [CTL_W-1:0] ctl_raw, ctl_syn;
  ctl_t             c;
  ctl_t             ctl_rst;

  assign ctl_raw = {fast_sel, stop_mid, stop_code, pwr_down};
  assign ctl_rst = '{fast: 1'b0, stop_mid: 1'b0, code: '1, pd: 1'b0};

  clkdist_sync #(.W(CTL_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk_mst), .rst_n(rst_n), .d(ctl_raw), .rst_val(ctl_rst), .q(ctl_syn)
  );
  assign c = ctl_t'(ctl_syn);

  // ---------------- power-down sequencing ----------------
  logic [RC_W-1:0] rc_q;
  logic            pd_req, hold_q, all_off;

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n)            rc_q <= '0;
    else if (c.pd)         rc_q <= RC_W'(RESUME_CYC);
    else if (rc_q != '0)   rc_q <= rc_q - 1'b1;
  end

  assign pd_req = c.pd | (rc_q != '0);

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= pd_req & all_off;
  end

  // ---------------- shared phase counter ----------------
  logic [PH_W-1:0] ph_q, ph_d;

  clkdist_phase u_phase (
    .clk(clk_mst), .rst_n(rst_n), .hold(hold_q), .ph_q(ph_q), .ph_d(ph_d)
  );

  logic w100_q, w100_d, w50_q, w50_d, w25_q, w25_d;
  assign w100_q = ~ph_q[0];
  assign w100_d = ~ph_d[0];
  assign w50_q  = ~ph_q[1];
  assign w50_d  = ~ph_d[1];
  assign w25_q  = ~ph_q[2];
  assign w25_d  = ~ph_d[2];

  logic [1:0] tog100, tog50, tog25;
  assign tog100 = {1'b0, w100_q ^ w100_d};
  assign tog50  = {1'b0, w50_q ^ w50_d};
  assign tog25  = {1'b0, w25_q ^ w25_d};

  // ---------------- per-group gates ----------------
  logic en_main_q, en_main_d, en_half_q, en_half_d, en_lead_q, en_lead_d;
  logic [N_SKEW-1:0] en_lag_q, en_lag_d;
  logic [1:0] main_step;
  logic       main_wq, main_wd;

  // at master rate a full clock pulse is two transitions per cycle
  assign main_step = c.fast ? 2'd2 : tog100;
  assign main_wq   = c.fast ? 1'b0 : w100_q;
  assign main_wd   = c.fast ? 1'b0 : w100_d;

  clkdist_gate u_gate_main (
    .clk(clk_mst), .rst_n(rst_n), .req(pd_req), .lim(tcnt_t'(PD_N)),
    .step(main_step), .wave_q(main_wq), .wave_d(main_wd),
    .en_q(en_main_q), .en_d(en_main_d)
  );

  clkdist_gate u_gate_half (
    .clk(clk_mst), .rst_n(rst_n), .req(pd_req | c.stop_mid),
    .lim(pd_req ? tcnt_t'(PD_N) : tcnt_t'(STOP_MID_N)),
    .step(tog50), .wave_q(w50_q), .wave_d(w50_d),
    .en_q(en_half_q), .en_d(en_half_d)
  );

  clkdist_gate u_gate_lead (
    .clk(clk_mst), .rst_n(rst_n), .req(pd_req), .lim(tcnt_t'(PD_N)),
    .step(tog25), .wave_q(w25_q), .wave_d(w25_d),
    .en_q(en_lead_q), .en_d(en_lead_d)
  );

  for (genvar k = 0; k < N_SKEW; k++) begin : g_lag
    logic sel_k;
    assign sel_k = (c.code == CODE_W'(k));

    clkdist_gate u_gate_lag (
      .clk(clk_mst), .rst_n(rst_n), .req(pd_req | sel_k),
      .lim(pd_req ? tcnt_t'(PD_N) : tcnt_t'(STOP_LAG_N)),
      .step(tog25), .wave_q(w25_q), .wave_d(w25_d),
      .en_q(en_lag_q[k]), .en_d(en_lag_d[k])
    );

    always_ff @(negedge clk_mst or negedge rst_n) begin
      if (!rst_n) clk_lag[k] <= 1'b0;
      else        clk_lag[k] <= w25_q & en_lag_q[k];
    end
  end

  assign all_off = ~en_main_q & ~en_half_q & ~en_lead_q & ~(|en_lag_q);

  // ---------------- output registers ----------------
  logic main_slow_q, main_gate_n;

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) begin
      main_slow_q <= 1'b0;
      clk_half    <= '0;
      clk_lead    <= 1'b0;
    end else begin
      main_slow_q <= w100_d & en_main_d;
      clk_half    <= {2{w50_d & en_half_d}};
      clk_lead    <= w25_d & en_lead_d;
    end
  end

  // enable for the master-rate path changes only while the clock is low
  always_ff @(negedge clk_mst or negedge rst_n) begin
    if (!rst_n) main_gate_n <= 1'b0;
    else        main_gate_n <= en_main_q;
  end

  assign clk_main = c.fast ? (clk_mst & main_gate_n) : main_slow_q;

  // R8: once the set is parked, the registered outputs are all low
  p_parked_low_r8: assert property (@(posedge clk_mst) disable iff (!rst_n)
    hold_q |-> (!main_slow_q && clk_half == 2'b00 && !clk_lead));

  // R3: at half rate, a quarter-rate rise always comes with a main rise
  p_half_in_phase_r3: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (!c.fast && !pd_req && $rose(clk_half[0])) |-> $rose(main_slow_q));
endmodule

// File: tb/clkdist_gated_test.sv
module clkdist_gated_test;
  logic       clk_mst = 1'b0;
  logic       rst_n;
  logic       fast_sel, stop_mid, pwr_down;
  logic [1:0] stop_code;
  logic       clk_main, clk_lead;
  logic [1:0] clk_half;
  logic [2:0] clk_lag;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_mst = ~clk_mst;

  clkdist_gated uut (
    .clk_mst(clk_mst), .rst_n(rst_n), .fast_sel(fast_sel), .stop_mid(stop_mid),
    .stop_code(stop_code), .pwr_down(pwr_down), .clk_main(clk_main),
    .clk_half(clk_half), .clk_lead(clk_lead), .clk_lag(clk_lag)
  );

  // bit map: 0 main, 1..2 half, 3 lead, 4..6 lag
  logic [6:0] cur, prv, rose, prose;
  int  tcnt [7];
  int  rcnt [7];
  bit  mon_en = 1'b0;
  int  viol   = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic take();
    cur  = {clk_lag, clk_lead, clk_half, clk_main};
    rose = cur & ~prv;
    for (int k = 0; k < 7; k++) begin
      if (cur[k] != prv[k]) tcnt[k]++;
      if (rose[k])          rcnt[k]++;
    end
    if (mon_en) begin
      if ((rose[1] | rose[2] | rose[3]) && !rose[0]) viol++;   // R3
      for (int k = 4; k < 7; k++)
        if (rose[k] && !prose[3]) viol++;                      // R4
    end
    prose = rose;
    prv   = cur;
  endtask

  initial begin
    prv = '0; prose = '0;
    for (int k = 0; k < 7; k++) begin tcnt[k] = 0; rcnt[k] = 0; end
    forever begin
      @(posedge clk_mst); #5; take();
      @(negedge clk_mst); #5; take();
    end
  end

  task automatic clr();
    for (int k = 0; k < 7; k++) begin tcnt[k] = 0; rcnt[k] = 0; end
  endtask

  task automatic slot();
    @(posedge clk_mst); #12;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk_mst);
    #12;
  endtask

  function automatic int exp_rise(input int k, input bit fast, input logic [1:0] code);
    if (k == 0)      return fast ? 64 : 32;
    else if (k < 3)  return 16;
    else if (k == 3) return 8;
    else             return (code == 2'(k - 4)) ? 0 : 8;
  endfunction

  task automatic window_rates(input bit fast, input logic [1:0] code, input string rq);
    clr();
    cycles(64);
    for (int k = 0; k < 7; k++)
      chk(rcnt[k] == exp_rise(k, fast, code), rq, rcnt[k], exp_rise(k, fast, code));
  endtask

  task automatic power_cycle(input bit fast);
    int first;
    mon_en = 1'b0;
    slot(); fast_sel = fast;
    cycles(24);
    pwr_down = 1'b1; clr();
    cycles(40);
    for (int k = 0; k < 7; k++) begin
      chk(tcnt[k] >= 3 && tcnt[k] <= 10, "R8 drain transitions", tcnt[k], 3);
      chk(cur[k] == 1'b0, "R8 parked low", int'(cur[k]), 0);
    end
    clr();
    cycles(32);
    for (int k = 0; k < 7; k++)
      chk(tcnt[k] == 0, "R8 quiet while held", tcnt[k], 0);
    pwr_down = 1'b0;
    mon_en   = 1'b1;
    first    = 0;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk_mst); #5;
      if (first == 0 && clk_half[0]) first = i;
      if (i < 6)
        chk(!clk_main && clk_half == 2'b00 && !clk_lead, "R9 low before restart",
            int'({clk_main, clk_half, clk_lead}), 0);
      if (i == 6) begin
        chk(clk_main && clk_lead && clk_half == 2'b11, "R9 common rise",
            int'({clk_main, clk_half, clk_lead}), 15);
        chk(clk_lag == 3'b000, "R9 lag not yet", int'(clk_lag), 0);
        #10;
        chk(clk_lag == 3'b111, "R9 lag half period later", int'(clk_lag), 7);
      end
    end
    chk(first == 6, "R9 restart edge", first, 6);
  endtask

  // watchdog
  initial begin
    #(100000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int v0;
    void'($urandom(32'd20001));
    rst_n = 1'b0; fast_sel = 1'b0; stop_mid = 1'b0; pwr_down = 1'b0; stop_code = 2'b11;
    repeat (3) @(posedge clk_mst);
    #5;
    chk({clk_main, clk_half, clk_lead, clk_lag} == 7'd0, "R1 reset low",
        int'({clk_main, clk_half, clk_lead, clk_lag}), 0);
    #7;
    rst_n  = 1'b1;
    mon_en = 1'b1;
    cycles(20);

    // baseline rates, half-rate main
    window_rates(1'b0, 2'b11, "R2 baseline rates");

    // mid-stop
    stop_mid = 1'b1; clr();
    cycles(30);
    chk(tcnt[1] >= 2 && tcnt[1] <= 3, "R5 half0 transitions", tcnt[1], 2);
    chk(tcnt[2] >= 2 && tcnt[2] <= 3, "R5 half1 transitions", tcnt[2], 2);
    chk(clk_half == 2'b00, "R5 half held low", int'(clk_half), 0);
    clr();
    cycles(32);
    chk(tcnt[1] == 0 && tcnt[2] == 0, "R5 half quiet", tcnt[1] + tcnt[2], 0);
    chk(rcnt[0] == 16, "R5 main keeps running", rcnt[0], 16);
    chk(rcnt[3] == 4, "R5 lead keeps running", rcnt[3], 4);
    stop_mid = 1'b0;
    cycles(16);
    window_rates(1'b0, 2'b11, "R5 restored rates");

    // stop code per lag output
    for (int s = 0; s < 3; s++) begin
      stop_code = 2'(s); clr();
      cycles(40);
      chk(tcnt[4+s] >= 2 && tcnt[4+s] <= 4, "R7 lag stop transitions", tcnt[4+s], 2);
      chk(cur[4+s] == 1'b0, "R7 lag held low", int'(cur[4+s]), 0);
      clr();
      cycles(32);
      for (int k = 4; k < 7; k++)
        chk(rcnt[k] == ((k == 4 + s) ? 0 : 4), "R6 code mapping", rcnt[k],
            (k == 4 + s) ? 0 : 4);
      chk(rcnt[3] == 4, "R6 lead unaffected", rcnt[3], 4);
      stop_code = 2'b11;
      cycles(16);
    end
    window_rates(1'b0, 2'b11, "R7 lag restored");
    chk(viol == 0, "R3 R4 phase relations directed", viol, 0);

    // power-down at both main rates
    power_cycle(1'b0);
    power_cycle(1'b1);
    cycles(8);
    chk(viol == 0, "R9 R3 R4 phase after restart", viol, 0);

    // random rate/code mixes
    for (int r = 0; r < 10; r++) begin
      bit          f;
      logic [1:0]  cd;
      f  = 1'($urandom % 2);
      cd = 2'($urandom % 4);
      mon_en = 1'b0;
      fast_sel = f; stop_code = cd;
      cycles(24);
      mon_en = 1'b1;
      v0 = viol;
      window_rates(f, cd, "R2 R6 random rates");
      chk(viol == v0, "R3 R4 random phase", viol - v0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule